// File: doc/BRIEF.md
# Dual-Clock FIFO with Standard and Fall-Through Timing

This block is a first-in, first-out buffer whose write side and read side run on independent clocks. Words enter on the write clock while an active-low write enable is held low. They leave on the read clock in the order they were written. Pointers pass between the two domains as Gray code through two-stage synchronizers. Full, half-full and almost-full are derived on the write side. Empty and almost-empty are derived on the read side.

The read timing is chosen by a mode input that is captured while master reset is low. In standard timing, each word reaches the data output only on an enabled read. In fall-through timing, the oldest word moves to the output register by itself, and a read enable consumes it. Because the output register then holds one extra word, the buffer accepts one word more than its memory depth.

The block has two resets. Master reset clears the buffer and captures the mode. Partial reset empties the buffer and keeps the mode. A retransmit pulse moves reading back to the first memory location, so that data written since the last reset can be read again. The almost-empty and almost-full thresholds come from a separate offset block as plain inputs.

Top module: `dcfifo_twomode`

## Requirements
- R1: Words written on rising `wclk` edges with `wen_n` low and the buffer not full are read back on `rclk` in the same order, with no word lost or repeated.
- R2: In standard timing (`fwft_sel` = 0 at master reset), `full_ir` is 1 when the buffer can accept data and 0 once 2^AW words are stored. A write while it is 0 is ignored.
- R3: In fall-through timing (`fwft_sel` = 1 at master reset), `full_ir` is 0 while the buffer can accept data and becomes 1 only after 2^AW + 1 words are stored. The oldest word appears on `dout` with `empty_or` = 0 without any read enable.
- R4: In standard timing, `empty_or` is 0 exactly when no word is stored. A read while it is 0 is ignored. `dout` changes only on an enabled read of stored data.
- R5: `hf_n` is 0 while more than 2^AW / 2 words are held in the memory array, and 1 otherwise.
- R6: `paf_n` is 0 while the number of words in the memory array is at least 2^AW − `af_off`, and 1 otherwise.
- R7: `pae_n` is 0 while the number of words in the memory array, not counting the fall-through output register, is at most `ae_off`.
- R8: The timing mode is captured from `fwft_sel` only while `mrst_n` is low. A partial reset (`prst_n` low) empties the buffer but keeps the mode.
- R9: A one-cycle `rewind` pulse on `rclk` restarts reading at memory location 0. In standard timing, every word after it, including the first, needs `ren_n` low. In fall-through timing, word 0 is presented on `dout` by itself.
- R10: After the first write into an empty buffer, `empty_or` changes state no later than the third rising `rclk` edge in standard timing, or the fourth in fall-through timing. After the first read from a full standard buffer, `full_ir` returns to 1 no later than the third rising `wclk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mrst_n | input | 1 | Master reset, active low, asynchronous; captures the mode |
| prst_n | input | 1 | Partial reset, active low, asynchronous; keeps the mode |
| fwft_sel | input | 1 | Timing mode sampled during master reset: 0 standard, 1 fall-through |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low; high puts `dout` in high impedance |
| rewind | input | 1 | Retransmit request, one `rclk` cycle |
| ae_off | input | AW+1 | Almost-empty offset |
| af_off | input | AW+1 | Almost-full offset |
| dout | output | DW | Read data |
| full_ir | output | 1 | Full flag (standard, low = full) or input-ready (fall-through, high = not ready) |
| empty_or | output | 1 | Empty flag (standard, low = empty) or output-ready (fall-through, high = no word) |
| hf_n | output | 1 | Half-full, active low |
| pae_n | output | 1 | Almost-empty, active low |
| paf_n | output | 1 | Almost-full, active low |

## Verification
The hardest state to reach is a fall-through buffer holding exactly 2^AW + 1 words, one in the output register and the rest in memory. A write attempted in that state must be dropped. The directed part reaches it by writing one word, waiting until it falls through, and then writing until `full_ir` flips. Random phases run the two clocks at unrelated periods and skew the write and read rates toward filling and then toward draining. The flags therefore meet both full and empty repeatedly, while a scoreboard keyed on the port flags checks every word.

// File: rtl/dcfifo_twomode.sv
module dcfifo_twomode #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          rclk,
  input  logic          ren_n,
  input  logic          oe_n,
  input  logic          rewind,
  input  logic [AW:0]   ae_off,
  input  logic [AW:0]   af_off,
  output logic [DW-1:0] dout,
  output logic          full_ir,
  output logic          empty_or,
  output logic          hf_n,
  output logic          pae_n,
  output logic          paf_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DFULL = PW'(DEPTH);
  localparam logic [PW-1:0] DHALF = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  logic mode;
  always_ff @(posedge rclk or negedge mrst_n)
    if (!mrst_n) mode <= fwft_sel;

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wptr, wgray, rs1, rs2, wcnt;
  logic full, wr_ok;
  assign wcnt  = wptr - g2b(rs2);
  assign full  = (wcnt == DFULL);
  assign wr_ok = !wen_n && !full;

  always_ff @(posedge wclk)
    if (wr_ok) mem[wptr[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0; wgray <= '0; rs1 <= '0; rs2 <= '0;
    end else begin
      rs1 <= rgray_w;
      rs2 <= rs1;
      if (wr_ok) begin
        wptr  <= wptr + 1'b1;
        wgray <= (wptr + 1'b1) ^ ((wptr + 1'b1) >> 1);
      end
    end

  logic [PW-1:0] rgray_w;
  assign full_ir = mode ? full : !full;
  assign hf_n    = !(wcnt > DHALF);
  assign paf_n   = !(wcnt >= DFULL - af_off);

  // read domain
  logic [PW-1:0] rptr, rgray, ws1, ws2, rcnt;
  logic [DW-1:0] q;
  logic ov, mempty, rd_std, load_ft, pop;
  assign rgray_w = rgray;
  assign rcnt    = g2b(ws2) - rptr;
  assign mempty  = (rcnt == '0);
  assign rd_std  = !mode && !ren_n && !mempty;
  assign load_ft = mode && !mempty && (!ov || !ren_n);
  assign pop     = rd_std || load_ft;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rptr <= '0; rgray <= '0; ws1 <= '0; ws2 <= '0; ov <= 1'b0; q <= '0;
    end else begin
      ws1 <= wgray;
      ws2 <= ws1;
      if (rewind) begin
        rptr <= '0; rgray <= '0; ov <= 1'b0;
      end else begin
        if (pop) begin
          q     <= mem[rptr[AW-1:0]];
          rptr  <= rptr + 1'b1;
          rgray <= (rptr + 1'b1) ^ ((rptr + 1'b1) >> 1);
        end
        if (mode) begin
          if (load_ft) ov <= 1'b1;
          else if (!ren_n) ov <= 1'b0;
        end
      end
    end

  assign empty_or = mode ? !ov : !mempty;
  assign pae_n    = !(rcnt <= ae_off);
  assign dout     = oe_n ? {DW{1'bz}} : q;

  assert_wr_bound_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    wcnt <= DFULL);
  assert_rd_bound_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    rcnt <= DFULL);
  assert_std_hold_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode && ren_n) |=> $stable(q));
  assert_ft_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode && ov && ren_n && !rewind) |=> (ov && $stable(q)));
  assert_full_hf_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> !hf_n);
  assert_full_paf_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> !paf_n);
  assert_empty_pae_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    mempty |-> !pae_n);
endmodule

// File: tb/dcfifo_twomode_test.sv
module dcfifo_twomode_test;
  localparam int DW = 9, AW = 4, D = 16;
  logic mrst_n = 0, prst_n = 1, fwft_sel = 0, wclk = 0, rclk = 0;
  logic wen_n = 1, ren_n = 1, oe_n = 0, rewind = 0;
  logic [DW-1:0] din = '0;
  logic [AW:0] ae_off = 5'd2, af_off = 5'd3;
  wire  [DW-1:0] dout;
  wire full_ir, empty_or, hf_n, pae_n, paf_n;

  dcfifo_twomode #(.DW(DW), .AW(AW)) uut (.*);

  always #5 wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  int nchk = 0, nfail = 0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] exp_w [0:D];

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic mreset(input logic m);
    @(negedge wclk); mrst_n = 0; fwft_sel = m;
    repeat (3) @(negedge rclk);
    mrst_n = 1; fwft_sel = 0;
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr(input logic [DW-1:0] v);
    @(negedge wclk); wen_n = 0; din = v;
    @(negedge wclk); wen_n = 1;
  endtask

  task automatic rd();
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
  endtask

  task automatic settle();
    repeat (4) @(negedge rclk);
    repeat (3) @(negedge wclk);
    @(negedge rclk);
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'(9'h0A5 ^ (i * 37));
  endfunction

  task automatic rand_run(input logic m, input int nw, input int nr);
    fork
      begin
        for (int i = 0; i < nw; i++) begin
          logic w;
          @(negedge wclk);
          w = (i < nw / 2) ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
          if (w && (m ? full_ir == 0 : full_ir == 1)) sb.push_back(din);
          wen_n = !w;
          din = DW'($urandom);
          if (w && (m ? full_ir == 0 : full_ir == 1)) sb[$] = din;
        end
        @(negedge wclk); wen_n = 1;
      end
      begin
        logic pend = 0;
        logic [DW-1:0] e = '0;
        for (int i = 0; i < nr; i++) begin
          logic r;
          @(negedge rclk);
          if (!m && pend) begin chk("R1 std order", dout, e); pend = 0; end
          if (m && empty_or == 0) chk("R1 ft order", dout, sb[0]);
          r = (i < nr / 2) ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
          if (r && (m ? empty_or == 0 : empty_or == 1)) begin
            e = sb.pop_front(); pend = 1;
          end
          ren_n = !r;
        end
        @(negedge rclk); ren_n = 1;
        if (!m && pend) begin @(negedge rclk); chk("R1 std order", dout, e); end
      end
    join
  endtask

  initial begin
    #3_000_000;
    nfail++; nchk++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd11));
    // standard mode, reset state
    mreset(0);
    chk("R2 reset full_ir", full_ir, 1);
    chk("R4 reset empty_or", empty_or, 0);
    chk("R5 reset hf_n", hf_n, 1);
    chk("R6 reset paf_n", paf_n, 1);
    chk("R7 reset pae_n", pae_n, 0);
    // R10 empty to non-empty latency
    @(negedge wclk); wen_n = 0; din = 9'h1C3;
    @(posedge wclk); #1 wen_n = 1;
    repeat (3) @(posedge rclk);
    @(negedge rclk);
    chk("R10 std empty_or latency", empty_or, 1);
    rd();
    chk("R1 single word", dout, 9'h1C3);
    chk("R4 empty after read", empty_or, 0);
    rd();
    chk("R4 read when empty ignored", dout, 9'h1C3);
    // fill with flag thresholds
    for (int k = 1; k <= D; k++) begin
      exp_w[k-1] = pat(k);
      wr(pat(k));
      settle();
      chk("R2 full_ir vs count", full_ir, (k == D) ? 0 : 1);
      chk("R5 hf_n vs count", hf_n, (k > D / 2) ? 0 : 1);
      chk("R6 paf_n vs count", paf_n, (k >= D - 3) ? 0 : 1);
      chk("R7 pae_n vs count", pae_n, (k <= 2) ? 0 : 1);
    end
    wr(9'h055);
    settle();
    chk("R2 write when full keeps full", full_ir, 0);
    // R10 full to not-full latency
    @(negedge rclk); ren_n = 0;
    @(posedge rclk); #1 ren_n = 1;
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    chk("R10 full_ir release latency", full_ir, 1);
    @(negedge rclk);
    chk("R1 first of full", dout, exp_w[0]);
    for (int k = 1; k < D; k++) begin
      rd();
      chk("R1 drain order", dout, exp_w[k]);
    end
    rd();
    chk("R2 write while full was dropped", dout, exp_w[D-1]);
    chk("R4 empty after drain", empty_or, 0);

    // R9 retransmit, standard
    mreset(0);
    for (int k = 0; k < 5; k++) begin exp_w[k] = pat(k + 50); wr(pat(k + 50)); end
    settle();
    for (int k = 0; k < 3; k++) begin rd(); chk("R9 pre-rewind read", dout, exp_w[k]); end
    @(negedge rclk); rewind = 1; @(negedge rclk); rewind = 0;
    settle();
    chk("R9 std no word without read", dout, exp_w[2]);
    chk("R9 std data available", empty_or, 1);
    for (int k = 0; k < 5; k++) begin rd(); chk("R9 std replay", dout, exp_w[k]); end
    chk("R9 std empty after replay", empty_or, 0);

    // fall-through mode
    mreset(1);
    chk("R3 ft reset empty_or", empty_or, 1);
    chk("R3 ft reset full_ir", full_ir, 0);
    exp_w[0] = 9'h0F1;
    @(negedge wclk); wen_n = 0; din = exp_w[0];
    @(posedge wclk); #1 wen_n = 1;
    repeat (4) @(posedge rclk);
    @(negedge rclk);
    chk("R10 ft empty_or latency", empty_or, 0);
    chk("R3 ft fall-through word", dout, exp_w[0]);
    for (int k = 1; k <= D; k++) begin
      exp_w[k] = pat(k + 90);
      wr(exp_w[k]);
      if (k == D - 1) begin settle(); chk("R3 ft ready at D words", full_ir, 0); end
    end
    settle();
    chk("R3 ft not ready at D+1 words", full_ir, 1);
    wr(9'h1EE);
    for (int k = 0; k <= D; k++) begin
      settle();
      chk("R3 ft drain order", dout, exp_w[k]);
      rd();
    end
    settle();
    chk("R3 ft write when full dropped", empty_or, 1);

    // R8 partial reset keeps fall-through mode
    wr(9'h011); wr(9'h022);
    settle();
    @(negedge wclk); prst_n = 0; fwft_sel = 0;
    repeat (3) @(negedge rclk);
    prst_n = 1;
    settle();
    chk("R8 partial reset empties (ft polarity)", empty_or, 1);
    chk("R8 partial reset ready (ft polarity)", full_ir, 0);
    for (int k = 0; k < 4; k++) begin exp_w[k] = pat(k + 200); wr(exp_w[k]); end
    settle();
    chk("R8 mode kept, word falls through", dout, exp_w[0]);
    rd(); rd();
    settle();
    chk("R9 ft head before rewind", dout, exp_w[2]);
    @(negedge rclk); rewind = 1; @(negedge rclk); rewind = 0;
    settle();
    chk("R9 ft first word presented", dout, exp_w[0]);
    chk("R9 ft output ready", empty_or, 0);

    // random phases
    mreset(0);
    sb.delete();
    rand_run(0, 3000, 2400);
    settle();
    while (sb.size() > 0) begin rd(); chk("R1 std tail", dout, sb.pop_front()); end
    chk("R4 std empty at end", empty_or, 0);
    mreset(1);
    sb.delete();
    rand_run(1, 3000, 2400);
    settle();
    while (sb.size() > 0) begin settle(); chk("R1 ft tail", dout, sb.pop_front()); rd(); end
    settle();
    chk("R3 ft empty at end", empty_or, 1);
    summary();
  end
endmodule